// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block produces the bit clock for one serial channel. A 16-bit time constant, loaded one byte at a time through a small write port, sets the rate. The output is a square wave whose period is 2 × (TC + 2) source periods, so TC = f_src / f_out / 2 − 2. Any oversampling factor used by the channel is applied by software when it picks TC. Setting TC to zero gives the fastest rate, one quarter of the source.

A control register starts and stops the generator and selects its source. The source is either the system clock itself or rising edges on an external clock pin, which the block first brings into the system clock domain. The square wave feeds the transmit and receive clocking. A one-cycle tick marks each rising edge of the square wave for logic that runs on the system clock.

Top module: `baud_gen`

## Requirements
- R1: After reset `baud_clk` and `baud_tick` are low, the time constant is zero and the generator is stopped, so no tick appears until it is enabled.
- R2: Write address 0 loads time-constant bits 7:0, address 1 loads bits 15:8, and address 2 loads the control register, where bit 0 is the run enable and bit 1 selects the source (0 = system clock, 1 = external pin). A write to address 3 changes nothing.
- R3: While running from the system clock, `baud_clk` toggles every TC + 2 cycles, which gives a period of 2 × (TC + 2) cycles with exactly TC + 2 cycles high.
- R4: TC = 0 gives a period of 4 source periods.
- R5: `baud_tick` is high for exactly one cycle, in the same cycle that `baud_clk` first reads high, and never on two cycles in a row.
- R6: With the external source selected, each rising edge of the pin, after synchronisation, counts as one source period. A pin period of P system cycles therefore gives an output period of 2 × (TC + 2) × P cycles.
- R7: A time constant written mid half-period does not shorten or stretch that half-period. It applies from the next toggle onwards.
- R8: While stopped, `baud_clk` holds its level, no tick is issued, and the counter is preset from the time constant. The first toggle after an enable write therefore comes TC + 2 cycles after that write's clock edge.
- R9: With the external source selected and the pin held still, `baud_clk` does not change and no tick is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| ext_clk | input | 1 | External clock pin, asynchronous to `clk` |
| baud_clk | output | 1 | Square-wave bit clock |
| baud_tick | output | 1 | One-cycle pulse on each rising edge of `baud_clk` |

## Verification
A register write takes effect at the clock edge that samples it. Running from the system clock, the first rise of `baud_clk` falls TC + 2 edges after the enable edge when it starts low, or 2 × (TC + 2) edges after it when it was held high. The bench records a free-running edge count at each write and at each tick, and compares the differences with these figures. On the external path the synchroniser adds a fixed delay, so those checks use only tick-to-tick spacing, which the delay cannot shift. All outputs are sampled on the falling edge. After a new time constant, the bench skips the periods whose length R7 leaves mixed, except in the test that checks that mixed period on purpose.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned CTRL_RUN    = 0;
  localparam int unsigned CTRL_SRCSEL = 1;

  typedef struct packed {
    logic src_ext;
    logic run;
  } ctrl_t;

endpackage

// File: rtl/baud_gen_regs.sv
module baud_gen_regs
  import baud_gen_pkg::*;
#(
  parameter int unsigned TC_W   = 16,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [TC_W-1:0]   tc,
  output ctrl_t             ctrl
);

  localparam int unsigned TC_BYTES  = TC_W / BYTE_W;
  localparam int unsigned CTRL_ADDR = TC_BYTES;

  logic [TC_W-1:0] tc_q, tc_d;
  ctrl_t           ctrl_q, ctrl_d;

  // one byte lane per slice of the time constant, lowest address = lowest byte
  for (genvar b = 0; b < TC_BYTES; b++) begin : g_tc_lane
    always_comb begin
      tc_d[b*BYTE_W +: BYTE_W] = tc_q[b*BYTE_W +: BYTE_W];
      if (wr_en && (wr_addr == ADDR_W'(b)))
        tc_d[b*BYTE_W +: BYTE_W] = wr_data;
    end
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en && (wr_addr == ADDR_W'(CTRL_ADDR))) begin
      ctrl_d.run     = wr_data[CTRL_RUN];
      ctrl_d.src_ext = wr_data[CTRL_SRCSEL];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q   <= '0;
      ctrl_q <= '0;
    end else begin
      tc_q   <= tc_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign tc   = tc_q;
  assign ctrl = ctrl_q;

endmodule

// File: rtl/baud_gen_src.sv
module baud_gen_src #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  input  logic src_ext,
  output logic src_tick
);

  // SYNC_STAGES flops of synchroniser plus one history flop for edge detection
  logic [SYNC_STAGES:0] shift_q, shift_d;
  logic                 ext_rise;

  always_comb begin
    shift_d = {shift_q[SYNC_STAGES-1:0], ext_clk};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign ext_rise = shift_q[SYNC_STAGES-1] & ~shift_q[SYNC_STAGES];
  assign src_tick = src_ext ? ext_rise : 1'b1;

endmodule

// File: rtl/baud_gen_div.sv
module baud_gen_div #(
  parameter int unsigned TC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            src_tick,
  input  logic [TC_W-1:0] tc,
  output logic            level,
  output logic            rise_tick
);

  localparam int unsigned CNT_W = TC_W + 1;

  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lvl_q, lvl_d;
  logic             tick_q, tick_d;
  logic             terminal;

  // half period = TC + 2 source periods: count TC+1 down to zero, toggle on zero
  assign reload   = {1'b0, tc} + CNT_W'(1);
  assign terminal = (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    lvl_d  = lvl_q;
    tick_d = 1'b0;
    if (!run) begin
      cnt_d = reload;
    end else if (src_tick) begin
      if (terminal) begin
        cnt_d  = reload;
        lvl_d  = ~lvl_q;
        tick_d = ~lvl_q;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lvl_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lvl_q  <= lvl_d;
      tick_q <= tick_d;
    end
  end

  assign level     = lvl_q;
  assign rise_tick = tick_q;

endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_gen_pkg::*;
#(
  parameter int unsigned TC_W        = 16,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ext_clk,
  output logic              baud_clk,
  output logic              baud_tick
);

  logic [TC_W-1:0] tc;
  ctrl_t           ctrl;
  logic            gen_en;
  logic            src_tick;

  baud_gen_regs #(.TC_W(TC_W), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .tc      (tc),
    .ctrl    (ctrl)
  );

  assign gen_en = ctrl.run;

  baud_gen_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_clk  (ext_clk),
    .src_ext  (ctrl.src_ext),
    .src_tick (src_tick)
  );

  baud_gen_div #(.TC_W(TC_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (gen_en),
    .src_tick  (src_tick),
    .tc        (tc),
    .level     (baud_clk),
    .rise_tick (baud_tick)
  );

endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic src_tick,
  input logic baud_clk,
  input logic baud_tick
);

  // R5: a tick only in the cycle the square wave has just gone high
  a_r5_tick_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> (baud_clk && !$past(baud_clk)));

  // R5: every rise of the square wave carries a tick
  a_r5_rise_has_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(baud_clk) |-> baud_tick);

  // R5: ticks are single-cycle
  a_r5_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |=> !baud_tick);

  // R8: stopped generator holds its level
  a_r8_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(baud_clk));

  // R8: stopped generator issues no tick
  a_r8_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !baud_tick);

  // R9: without a source period the output cannot move
  a_r9_no_source_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !src_tick) |=> $stable(baud_clk));

endmodule

bind baud_gen baud_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (gen_en),
  .src_tick  (src_tick),
  .baud_clk  (baud_clk),
  .baud_tick (baud_tick)
);

// File: tb/baud_gen_tb.sv
module baud_gen_tb;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       ext_clk;
  logic       baud_clk;
  logic       baud_tick;

  int n_checks;
  int n_fail;
  int cyc;
  bit done;
  bit ext_run;

  baud_gen u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ext_clk   (ext_clk),
    .baud_clk  (baud_clk),
    .baud_tick (baud_tick)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // external pin: period of 6 system cycles when running
  initial begin
    ext_clk = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      if (ext_run) ext_clk = ~ext_clk;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_tick(output int at);
    while (!baud_tick) @(negedge clk);
    at = cyc;
    @(negedge clk);
  endtask

  task automatic quiet_window(input int n, input string req);
    logic lvl;
    int   ticks;
    int   moves;
    lvl   = baud_clk;
    ticks = 0;
    moves = 0;
    repeat (n) begin
      @(negedge clk);
      if (baud_tick) ticks++;
      if (baud_clk !== lvl) moves++;
    end
    check(ticks == 0, {req, " tick count"}, ticks, 0);
    check(moves == 0, {req, " level changes"}, moves, 0);
  endtask

  task automatic test_reset;
    check(baud_clk == 1'b0, "R1 baud_clk after reset", baud_clk, 0);
    check(baud_tick == 1'b0, "R1 baud_tick after reset", baud_tick, 0);
    quiet_window(40, "R1 idle after reset");
  endtask

  task automatic test_unused_addr;
    write_reg(2'd3, 8'hFF);
    quiet_window(40, "R2 address 3 ignored");
  endtask

  task automatic test_start_and_duty;
    int e, t0, t1, high;
    write_reg(2'd0, 8'd5);
    write_reg(2'd1, 8'd0);
    write_reg(2'd2, 8'h01);
    e = cyc;
    wait_tick(t0);
    check(t0 - e == 7, "R8 first rise after enable", t0 - e, 7);
    high = 1;
    repeat (13) begin
      if (baud_clk) high++;
      @(negedge clk);
    end
    check(high == 7, "R3 high cycles TC=5", high, 7);
    wait_tick(t1);
    check(t1 - t0 == 14, "R3 period TC=5", t1 - t0, 14);
    check(baud_tick == 1'b0, "R5 tick one cycle wide", baud_tick, 0);
  endtask

  task automatic test_tc_change;
    int t0, t1, t2;
    wait_tick(t0);
    write_reg(2'd0, 8'd2);
    wait_tick(t1);
    check(t1 - t0 == 11, "R7 mixed period after change", t1 - t0, 11);
    wait_tick(t2);
    check(t2 - t1 == 8, "R7 period with new TC=2", t2 - t1, 8);
  endtask

  task automatic test_disable_hold;
    int t0, e, t1;
    wait_tick(t0);
    write_reg(2'd2, 8'h00);
    check(baud_clk == 1'b1, "R8 level high when stopped", baud_clk, 1);
    quiet_window(60, "R8 stopped");
    write_reg(2'd2, 8'h01);
    e = cyc;
    wait_tick(t1);
    check(t1 - e == 8, "R8 restart from high TC=2", t1 - e, 8);
  endtask

  task automatic test_tc_zero;
    int t0, t1;
    write_reg(2'd0, 8'd0);
    wait_tick(t0);
    wait_tick(t0);
    wait_tick(t1);
    check(t1 - t0 == 4, "R4 period TC=0", t1 - t0, 4);
  endtask

  task automatic test_high_byte;
    int t0, t1;
    write_reg(2'd1, 8'h01);
    write_reg(2'd0, 8'h02);
    wait_tick(t0);
    wait_tick(t0);
    wait_tick(t1);
    check(t1 - t0 == 520, "R2 R3 period TC=0x0102", t1 - t0, 520);
  endtask

  task automatic test_ext_idle;
    write_reg(2'd2, 8'h00);
    write_reg(2'd1, 8'h00);
    write_reg(2'd0, 8'h01);
    write_reg(2'd2, 8'h03);
    quiet_window(100, "R9 external pin still");
  endtask

  task automatic test_ext_clock;
    int t0, t1;
    ext_run = 1'b1;
    wait_tick(t0);
    wait_tick(t0);
    wait_tick(t1);
    check(t1 - t0 == 36, "R6 period external P=6 TC=1", t1 - t0, 36);
    ext_run = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    n_checks = 0;
    n_fail   = 0;
    done     = 1'b0;
    ext_run  = 1'b0;
    wr_en    = 1'b0;
    wr_addr  = '0;
    wr_data  = '0;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_unused_addr();
    test_start_and_duty();
    test_tc_change();
    test_disable_hold();
    test_tc_zero();
    test_high_byte();
    test_ext_idle();
    test_ext_clock();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule